// File: doc/BRIEF.md
# Store-and-Forward Stream Packet FIFO

This block is a single-clock queue between two AXI4-Stream links. Beats arrive on a slave port and leave on a master port. The head word always appears on the output without a read request: the output is fall-through. Each stored entry joins the user sideband, the last flag and the data into one word, so every field travels with its beat. Only the two handshake wires stay outside the stored word.

In packet mode the output stays silent until at least one whole packet is held. A packet counts as whole once its closing beat, the one with last set, has been stored. From then on the sink can take the head packet one beat per cycle with no gaps, because every beat of it is already inside. Outside packet mode the output offers data as soon as an occupancy condition is met.

Two parameters choose when the input stops accepting: when the queue is full, when one slot is left, or at a set fill level. Two more choose when the output offers data: when the queue is not empty, when it holds more than one word, or at a set fill level. Reset is asynchronous and active low.

Top module: `axis_pkt_fifo`

## Requirements
- R1: A beat moves only on a rising clock edge where valid and ready are both high on that port. Once the output valid is high, it stays high until a beat is taken.
- R2: Beats leave in the order they arrived. Each stored word is {user, last, data}, so the data, last flag and user field of a beat appear together on the output.
- R3: With the input stop mode set to full, `s_tready` is low while DEPTH words are held. A beat offered while `s_tready` is low is not stored.
- R4: In packet mode, `m_tvalid` stays low until the last beat of a packet has been stored. It rises in the cycle after that beat is accepted.
- R5: In packet mode, once the head packet is offered, `m_tvalid` stays high in every cycle up to and including its final beat while the sink holds `m_tready` high.
- R6: If a last beat is written and a last beat is read in the same cycle, the count of complete packets does not change. A complete packet still held stays offered.
- R7: While `rst_n` is low, the queue is empty at once, with no clock edge needed. `m_tvalid` is low and, in full mode, `s_tready` is high.
- R8: In the one-slot-left input mode, `s_tready` is low at DEPTH-1 words or more. In the level mode, it is low at FULL_LEVEL words or more.
- R9: Outside packet mode, the more-than-one output mode offers data only with two or more words held. The level output mode offers data only with EMPTY_LEVEL words or more held.
- R10: In packet mode, a packet must fit in the input capacity. A packet of exactly DEPTH beats is stored and delivered whole. An input stall with no complete packet held is flagged as a configuration error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_tvalid | input | 1 | Input beat present |
| s_tready | output | 1 | Queue accepts a beat |
| s_tdata | input | DATA_W | Input data |
| s_tuser | input | USER_W | Input user sideband |
| s_tlast | input | 1 | Input beat closes a packet |
| m_tvalid | output | 1 | Head beat offered |
| m_tready | input | 1 | Sink takes the head beat |
| m_tdata | output | DATA_W | Head data |
| m_tuser | output | USER_W | Head user sideband |
| m_tlast | output | 1 | Head beat closes a packet |

## Verification
The hardest case to reach is a cycle in which one packet's closing beat is written while an earlier packet's closing beat is read. The bench stores a one-beat packet and then the first beat of a second packet. In the next cycle it drives the second packet's last beat and raises the sink ready together, so both closing beats cross the ports on the same edge. It then checks that the second packet is still offered. A packet that fills the queue exactly is also driven with the sink stalled, to show it is released intact. Three instances with different stop and offer modes see the same traffic, so each mode's thresholds are checked on the same fill and drain sequence.

// File: rtl/axis_pfifo_pkg.sv
package axis_pfifo_pkg;

  typedef enum logic [1:0] {
    STOP_AT_FULL  = 2'd0,
    STOP_AT_NEAR  = 2'd1,
    STOP_AT_LEVEL = 2'd2
  } inStop_e;

  typedef enum logic [1:0] {
    SHOW_NONEMPTY  = 2'd0,
    SHOW_ABOVE_ONE = 2'd1,
    SHOW_AT_LEVEL  = 2'd2
  } outShow_e;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobes_t;

endpackage

// File: rtl/pfifo_store.sv
module pfifo_store
  import axis_pfifo_pkg::*;
#(
  parameter int WORD_W = 19,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  fifoStrobes_t      stb,
  input  logic [AW-1:0]     wrPtr,
  input  logic [AW-1:0]     rdPtr,
  input  logic [WORD_W-1:0] wrWord,
  output logic [WORD_W-1:0] rdWord
);

  logic [WORD_W-1:0] slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (stb.push && wrPtr == AW'(i)) slots[i] <= wrWord;
    end
  end

  // fall-through: the head slot drives the output directly
  assign rdWord = slots[rdPtr];

endmodule

// File: rtl/pfifo_ctrl.sv
module pfifo_ctrl
  import axis_pfifo_pkg::*;
#(
  parameter int      DEPTH       = 8,
  parameter bit      PACKET_MODE = 1'b1,
  parameter inStop_e  READY_MODE = STOP_AT_FULL,
  parameter outShow_e VALID_MODE = SHOW_NONEMPTY,
  parameter int      FULL_LEVEL  = 6,
  parameter int      EMPTY_LEVEL = 2,
  localparam int     AW          = $clog2(DEPTH),
  localparam int     CW          = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  input  logic          inLast,
  input  logic          outReady,
  input  logic          outLast,
  output logic          inReady,
  output logic          outValid,
  output fifoStrobes_t  stb,
  output logic [AW-1:0] wrPtr,
  output logic [AW-1:0] rdPtr
);

  logic [CW-1:0] level;
  logic [CW-1:0] pktCnt;
  logic          stopIn;
  logic          lowOut;
  logic          lastIn;
  logic          lastOut;

  always_comb begin
    unique case (READY_MODE)
      STOP_AT_NEAR:  stopIn = level >= CW'(DEPTH - 1);
      STOP_AT_LEVEL: stopIn = level >= CW'(FULL_LEVEL);
      default:       stopIn = level == CW'(DEPTH);
    endcase
    unique case (VALID_MODE)
      SHOW_ABOVE_ONE: lowOut = level < CW'(2);
      SHOW_AT_LEVEL:  lowOut = level < CW'(EMPTY_LEVEL);
      default:        lowOut = level == '0;
    endcase
  end

  assign inReady  = !stopIn;
  assign outValid = PACKET_MODE ? (pktCnt != '0) : !lowOut;

  assign stb.push = inValid && inReady;
  assign stb.pop  = outValid && outReady;
  assign lastIn   = stb.push && inLast;
  assign lastOut  = stb.pop && outLast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      pktCnt <= '0;
    end else begin
      if (stb.push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (stb.pop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      unique case ({stb.push, stb.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      // a closing beat in and one out on the same edge cancel
      unique case ({lastIn, lastOut})
        2'b10:   pktCnt <= pktCnt + 1'b1;
        2'b01:   pktCnt <= pktCnt - 1'b1;
        default: pktCnt <= pktCnt;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)); // R3
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid); // R1
  AST_PKT_WITHIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    pktCnt <= level); // R4
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    PACKET_MODE && stb.pop && !outLast |=> outValid); // R5
  AST_LAST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    lastIn && lastOut |=> $stable(pktCnt)); // R6
  AST_PKT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    PACKET_MODE && !inReady |-> pktCnt != '0); // R10

endmodule

// File: rtl/axis_pkt_fifo.sv
module axis_pkt_fifo
  import axis_pfifo_pkg::*;
#(
  parameter int       DATA_W      = 16,
  parameter int       USER_W      = 2,
  parameter int       DEPTH       = 8,
  parameter bit       PACKET_MODE = 1'b1,
  parameter inStop_e  READY_MODE  = STOP_AT_FULL,
  parameter outShow_e VALID_MODE  = SHOW_NONEMPTY,
  parameter int       FULL_LEVEL  = 6,
  parameter int       EMPTY_LEVEL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [USER_W-1:0] s_tuser,
  input  logic              s_tlast,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [USER_W-1:0] m_tuser,
  output logic              m_tlast
);

  localparam int WORD_W = USER_W + 1 + DATA_W;
  localparam int AW     = $clog2(DEPTH);

  fifoStrobes_t      stb;
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [WORD_W-1:0] wrWord;
  logic [WORD_W-1:0] rdWord;

  assign wrWord = {s_tuser, s_tlast, s_tdata};
  assign {m_tuser, m_tlast, m_tdata} = rdWord;

  pfifo_ctrl #(
    .DEPTH(DEPTH), .PACKET_MODE(PACKET_MODE), .READY_MODE(READY_MODE),
    .VALID_MODE(VALID_MODE), .FULL_LEVEL(FULL_LEVEL), .EMPTY_LEVEL(EMPTY_LEVEL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .inValid(s_tvalid), .inLast(s_tlast),
    .outReady(m_tready), .outLast(m_tlast),
    .inReady(s_tready), .outValid(m_tvalid),
    .stb(stb), .wrPtr(wrPtr), .rdPtr(rdPtr)
  );

  pfifo_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .stb(stb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrWord(wrWord), .rdWord(rdWord)
  );

  initial begin
    assert (DEPTH >= 2); // R10
  end

endmodule

// File: tb/axis_pkt_fifo_tb.sv
`timescale 1ns/1ps
module axis_pkt_fifo_tb;
  import axis_pfifo_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sValid = 1'b0, sLast = 1'b0, mReady = 1'b0;
  logic [15:0] sData = '0;
  logic [1:0]  sUser = '0;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  logic rdyP, vldP, lastP, rdyT, vldT, lastT, rdyN, vldN, lastN;
  logic [15:0] dataP, dataT, dataN;
  logic [1:0]  userP, userT, userN;

  axis_pkt_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .s_tvalid(sValid), .s_tready(rdyP),
    .s_tdata(sData), .s_tuser(sUser), .s_tlast(sLast),
    .m_tvalid(vldP), .m_tready(mReady), .m_tdata(dataP),
    .m_tuser(userP), .m_tlast(lastP));

  axis_pkt_fifo #(.PACKET_MODE(1'b0), .READY_MODE(STOP_AT_LEVEL),
    .VALID_MODE(SHOW_AT_LEVEL), .FULL_LEVEL(5), .EMPTY_LEVEL(3)) u_dutLvl (
    .clk(clk), .rst_n(rst_n), .s_tvalid(sValid), .s_tready(rdyT),
    .s_tdata(sData), .s_tuser(sUser), .s_tlast(sLast),
    .m_tvalid(vldT), .m_tready(mReady), .m_tdata(dataT),
    .m_tuser(userT), .m_tlast(lastT));

  axis_pkt_fifo #(.PACKET_MODE(1'b0), .READY_MODE(STOP_AT_NEAR),
    .VALID_MODE(SHOW_ABOVE_ONE)) u_dutNear (
    .clk(clk), .rst_n(rst_n), .s_tvalid(sValid), .s_tready(rdyN),
    .s_tdata(sData), .s_tuser(sUser), .s_tlast(sLast),
    .m_tvalid(vldN), .m_tready(mReady), .m_tdata(dataN),
    .m_tuser(userN), .m_tlast(lastN));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] d, input logic l, input logic r);
    sValid = v; sData = d; sUser = d[1:0] ^ 2'b01; sLast = l; mReady = r;
  endtask

  task automatic doReset();
    @(negedge clk);
    drive(1'b0, '0, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic testResetState();
    doReset();
    chk("R7 ready after reset", rdyP, 1);
    chk("R7 valid after reset", vldP, 0);
  endtask

  task automatic testPacketHold();
    doReset();
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, 16'(10 + i), 1'b0, 1'b0);
      @(negedge clk);
      chk("R4 held before last", vldP, 0);
    end
    drive(1'b1, 16'd13, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, 1'b0);
    chk("R4 offered after last", vldP, 1);
    chk("R2 head data", dataP, 10);
    mReady = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R5 no gap", vldP, 1);
      chk("R2 order", dataP, 32'(10 + i));
      chk("R2 last flag", lastP, (i == 3) ? 1 : 0);
      chk("R2 user field", userP, 32'(2'((10 + i) & 3) ^ 2'b01));
      @(negedge clk);
    end
    chk("R1 nothing left", vldP, 0);
  endtask

  task automatic testSameCycleLast();
    doReset();
    drive(1'b1, 16'd20, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b1, 16'd21, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 valid held while stalled", vldP, 1);
    drive(1'b1, 16'd22, 1'b1, 1'b1);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, 1'b0);
    chk("R6 next packet offered", vldP, 1);
    chk("R6 next packet head", dataP, 21);
    mReady = 1'b1;
    chk("R6 beat one", dataP, 21);
    @(negedge clk);
    chk("R6 valid on beat two", vldP, 1);
    chk("R6 beat two last", lastP, 1);
    @(negedge clk);
    chk("R6 drained", vldP, 0);
  endtask

  task automatic testFillModes();
    doReset();
    for (int k = 1; k <= 9; k++) begin
      drive(1'b1, 16'(k - 1), (k == 8), 1'b0);
      @(negedge clk);
      chk("R3 full mode ready", rdyP, (k < 8) ? 1 : 0);
      chk("R8 level mode ready", rdyT, (k < 5) ? 1 : 0);
      chk("R8 near mode ready", rdyN, (k < 7) ? 1 : 0);
      chk("R10 packet of depth", vldP, (k >= 8) ? 1 : 0);
      chk("R9 level mode valid", vldT, (k >= 3) ? 1 : 0);
      chk("R9 near mode valid", vldN, (k >= 2) ? 1 : 0);
    end
    drive(1'b0, '0, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      chk("R10 depth packet valid", vldP, 1);
      chk("R10 depth packet data", dataP, i);
      chk("R2 last on final", lastP, (i == 7) ? 1 : 0);
      chk("R9 level valid drain", vldT, (i <= 2) ? 1 : 0);
      if (i <= 2) chk("R9 level data", dataT, i);
      chk("R9 near valid drain", vldN, (i <= 5) ? 1 : 0);
      if (i <= 5) chk("R9 near data", dataN, i);
      @(negedge clk);
    end
    chk("R3 extra beat dropped", vldP, 0);
  endtask

  task automatic testAsyncReset();
    doReset();
    drive(1'b1, 16'd40, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, '0, 1'b0, 1'b0);
    chk("R4 offered before reset", vldP, 1);
    rst_n = 1'b0;
    #1;
    chk("R7 valid cleared without edge", vldP, 0);
    chk("R7 ready in reset", rdyP, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testResetState();
    testPacketHold();
    testSameCycleLast();
    testFillModes();
    testAsyncReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule